// File: doc/BRIEF.md
# Time Base and Decrementer Timer

A processor timer unit built from two counters that share one tick-enable input. A 64-bit time base counts up by one on every cycle in which the tick enable is high. A 32-bit decrementer counts down by one on the same ticks. Software reaches both counters through a small register port. The port selects one of four 32-bit slots with a 2-bit select: 0 is the time base low half, 1 is the time base high half, 2 is the decrementer, and 3 is unused.

The decrementer does not flag its event on reaching zero. It flags it when its sign bit (bit 31) goes from clear to set. That happens when a tick takes the count from zero to all ones, and when software writes a negative value over a non-negative one. The event latches a level interrupt, which stays high until an acknowledge pulse clears it.

A read of the low time-base half also copies the high half into a shadow register. A later high read returns that shadow, so a low-then-high read pair always gives one consistent 64-bit value.

Top module: `time_base_timer`

## Requirements
- R1: After reset the time base is 0, the decrementer holds 0xFFFFFFFF, the shadow and rdata_o are 0, and irq_o is low.
- R2: Each cycle with tick_i high and no time-base write adds one to the 64-bit time base, with carry from bit 31 into bit 32. Cycles without tick_i leave it unchanged.
- R3: A read result appears on rdata_o in the cycle after rd_en_i and holds until the next read. A read of select 0 returns time base bits 31:0 and copies bits 63:32 into the shadow. A read of select 1 returns the shadow.
- R4: A write to select 0 replaces time base bits 31:0 and keeps bits 63:32. A write to select 1 replaces bits 63:32 and keeps bits 31:0.
- R5: A time-base write in a tick cycle loads the written half, keeps the other half as it was, and drops that cycle's increment.
- R6: Each cycle with tick_i high and no decrementer write subtracts one from the decrementer. A read of select 2 returns the decrementer.
- R7: A tick that takes the decrementer from 0 to 0xFFFFFFFF raises irq_o in the next cycle. A tick from 0x80000000 to 0x7FFFFFFF raises nothing.
- R8: A write to select 2 raises irq_o in the next cycle only when the new value has bit 31 set and the old value had bit 31 clear. Any other write raises nothing.
- R9: A decrementer write in a tick cycle loads the written value and drops that cycle's decrement.
- R10: irq_o stays high until ack_i is pulsed, and it is low in the cycle after that pulse. When an event and ack_i fall in the same cycle, the event wins and irq_o stays high.
- R11: Select 3 reads as zero. Writes to select 3 change neither counter.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Tick enable shared by both counters |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| sel_i | input | 2 | Slot select: 0 low half, 1 high half, 2 decrementer, 3 unused |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Registered read data |
| ack_i | input | 1 | Interrupt acknowledge pulse |
| irq_o | output | 1 | Level interrupt from the decrementer |

## Verification
Every result of this block is due exactly one clock edge after its stimulus. A read, write, tick or acknowledge presented in one cycle shows up on rdata_o, in the counters or on irq_o after the next rising edge. The bench drives its inputs on the falling edge and updates a behavioural model with the same one-edge delay. At the next falling edge it compares rdata_o and irq_o against that model, then drives the next stimulus. Counter contents are checked by issuing reads through the normal port, and the directed reads also compare against constants worked out from the requirements.

// File: rtl/tbt_pkg.sv
package tbt_pkg;
  typedef enum logic [1:0] {
    SEL_TB_LO = 2'd0,
    SEL_TB_HI = 2'd1,
    SEL_DEC   = 2'd2,
    SEL_NONE  = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/tbt_time_base.sv
module tbt_time_base #(
  parameter int unsigned DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          wr_lo_i,
  input  logic          wr_hi_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          snap_i,
  output logic [DW-1:0] lo_o,
  output logic [DW-1:0] shadow_o
);
  localparam int unsigned TW = 2 * DW;

  logic [TW-1:0] tb_q;
  logic [DW-1:0] shadow_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tb_q <= '0;
    end else if (wr_lo_i) begin
      tb_q <= {tb_q[TW-1:DW], wdata_i};
    end else if (wr_hi_i) begin
      tb_q <= {wdata_i, tb_q[DW-1:0]};
    end else if (tick_i) begin
      tb_q <= tb_q + TW'(1);
    end
  end

  // shadow holds the high half seen at the last low read
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     shadow_q <= '0;
    else if (snap_i) shadow_q <= tb_q[TW-1:DW];
  end

  assign lo_o     = tb_q[DW-1:0];
  assign shadow_o = shadow_q;

  // R2
  tb_inc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i && !wr_lo_i && !wr_hi_i |=> tb_q == $past(tb_q) + TW'(1));
  // R4
  tb_keep_hi_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_lo_i |=> tb_q[TW-1:DW] == $past(tb_q[TW-1:DW]));
  // R4
  tb_keep_lo_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_hi_i && !wr_lo_i |=> tb_q[DW-1:0] == $past(tb_q[DW-1:0]));
endmodule

// File: rtl/tbt_decrementer.sv
module tbt_decrementer #(
  parameter int unsigned DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          wr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] cnt_o,
  output logic          ev_o
);
  localparam int unsigned SB = DW - 1;

  logic [DW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (wr_i)        cnt_d = wdata_i;
    else if (tick_i) cnt_d = cnt_q - DW'(1);
  end

  // sign bit going clear -> set, by tick or by write
  assign ev_o = cnt_d[SB] && !cnt_q[SB];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '1;
    else         cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;

  // R6
  dec_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i && !wr_i |=> cnt_q == $past(cnt_q) - DW'(1));
  // R9
  dec_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> cnt_q == $past(wdata_i));
endmodule

// File: rtl/tbt_irq.sv
module tbt_irq (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ev_i,
  input  logic ack_i,
  output logic irq_o
);
  logic irq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    irq_q <= 1'b0;
    else if (ev_i)  irq_q <= 1'b1;
    else if (ack_i) irq_q <= 1'b0;
  end

  assign irq_o = irq_q;

  // R7
  irq_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev_i |=> irq_o);
  // R10
  irq_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_i && !ev_i |=> !irq_o);
  // R10
  irq_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ack_i && !ev_i |=> $stable(irq_o));
endmodule

// File: rtl/time_base_timer.sv
module time_base_timer
  import tbt_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [1:0]        sel_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              ack_i,
  output logic              irq_o
);
  reg_sel_e          sel;
  logic              wr_lo, wr_hi, wr_dec, snap, ev;
  logic [DATA_W-1:0] tb_lo, tb_shadow, dec_cnt, rdata_q;

  assign sel    = reg_sel_e'(sel_i);
  assign wr_lo  = wr_en_i && (sel == SEL_TB_LO);
  assign wr_hi  = wr_en_i && (sel == SEL_TB_HI);
  assign wr_dec = wr_en_i && (sel == SEL_DEC);
  assign snap   = rd_en_i && (sel == SEL_TB_LO);

  tbt_time_base #(.DW(DATA_W)) u_tb (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (tick_i),
    .wr_lo_i  (wr_lo),
    .wr_hi_i  (wr_hi),
    .wdata_i  (wdata_i),
    .snap_i   (snap),
    .lo_o     (tb_lo),
    .shadow_o (tb_shadow)
  );

  tbt_decrementer #(.DW(DATA_W)) u_dec (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tick_i  (tick_i),
    .wr_i    (wr_dec),
    .wdata_i (wdata_i),
    .cnt_o   (dec_cnt),
    .ev_o    (ev)
  );

  tbt_irq u_irq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ev_i   (ev),
    .ack_i  (ack_i),
    .irq_o  (irq_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q <= '0;
    end else if (rd_en_i) begin
      unique case (sel)
        SEL_TB_LO: rdata_q <= tb_lo;
        SEL_TB_HI: rdata_q <= tb_shadow;
        SEL_DEC:   rdata_q <= dec_cnt;
        default:   rdata_q <= '0;
      endcase
    end
  end

  assign rdata_o = rdata_q;

  // R3
  rdata_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> $stable(rdata_o));
  // R11
  sel_none_rd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_i && sel_i == 2'd3 |=> rdata_o == '0);
endmodule

// File: tb/tb_time_base_timer.sv
module tb_time_base_timer;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        tick_i = 1'b0, wr_en_i = 1'b0, rd_en_i = 1'b0, ack_i = 1'b0;
  logic [1:0]  sel_i = 2'd0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        irq_o;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  logic [63:0] m_tb;
  logic [31:0] m_dec, m_sh, m_rd;
  logic        m_irq;

  always #5 clk = ~clk;

  time_base_timer dut (
    .clk_i(clk), .rst_ni(rst_ni), .tick_i(tick_i), .wr_en_i(wr_en_i),
    .rd_en_i(rd_en_i), .sel_i(sel_i), .wdata_i(wdata_i), .rdata_o(rdata_o),
    .ack_i(ack_i), .irq_o(irq_o)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // drive at negedge, advance model, compare at the next negedge
  task automatic step(input string tag, input bit tk, input bit wr, input bit rd,
                      input logic [1:0] s, input logic [31:0] wd, input bit ak);
    logic [31:0] nd;
    bit ev;
    tick_i = tk; wr_en_i = wr; rd_en_i = rd; sel_i = s; wdata_i = wd; ack_i = ak;
    ev = 1'b0;
    if (rd) begin
      case (s)
        2'd0: begin m_rd = m_tb[31:0]; end
        2'd1: m_rd = m_sh;
        2'd2: m_rd = m_dec;
        default: m_rd = 32'h0;
      endcase
      if (s == 2'd0) m_sh = m_tb[63:32];
    end
    if (wr && s == 2'd0)      m_tb = {m_tb[63:32], wd};
    else if (wr && s == 2'd1) m_tb = {wd, m_tb[31:0]};
    else if (tk)              m_tb = m_tb + 64'd1;
    if (wr && s == 2'd2) nd = wd;
    else if (tk)         nd = m_dec - 32'd1;
    else                 nd = m_dec;
    ev = nd[31] && !m_dec[31];
    m_dec = nd;
    if (ev)      m_irq = 1'b1;
    else if (ak) m_irq = 1'b0;
    @(negedge clk);
    tick_i = 1'b0; wr_en_i = 1'b0; rd_en_i = 1'b0; ack_i = 1'b0;
    check({tag, " rdata"}, rdata_o, m_rd);
    check({tag, " irq"}, {31'd0, irq_o}, {31'd0, m_irq});
  endtask

  task automatic rd(input string tag, input logic [1:0] s, input logic [31:0] exp);
    step(tag, 1'b0, 1'b0, 1'b1, s, 32'h0, 1'b0);
    check({tag, " const"}, rdata_o, exp);
  endtask

  task automatic wr(input string tag, input logic [1:0] s, input logic [31:0] d, input bit tk);
    step(tag, tk, 1'b1, 1'b0, s, d, 1'b0);
  endtask

  task automatic idle(input string tag, input int n, input bit tk);
    for (int i = 0; i < n; i++) step(tag, tk, 1'b0, 1'b0, 2'd0, 32'h0, 1'b0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    m_tb = '0; m_dec = 32'hFFFF_FFFF; m_sh = '0; m_rd = '0; m_irq = 1'b0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 rdata", rdata_o, 32'h0);
    check("R1 irq", {31'd0, irq_o}, 32'h0);
    rd("R1", 2'd2, 32'hFFFF_FFFF);
    rd("R1", 2'd0, 32'h0);
    rd("R1", 2'd1, 32'h0);

    // R2 counting and pausing
    idle("R2", 5, 1'b1);
    idle("R2", 4, 1'b0);
    rd("R2", 2'd0, 32'd5);

    // R4 half writes, R2 carry into the high half
    wr("R4", 2'd1, 32'h1234_5678, 1'b0);
    wr("R4", 2'd0, 32'hFFFF_FFFE, 1'b0);
    idle("R2", 3, 1'b1);
    rd("R2", 2'd0, 32'h0000_0001);
    rd("R3", 2'd1, 32'h1234_5679);

    // R3 shadow kept after the high half changes
    idle("R3", 2, 1'b1);
    wr("R4", 2'd1, 32'hAAAA_0000, 1'b0);
    rd("R3", 2'd1, 32'h1234_5679);
    rd("R3", 2'd0, 32'h0000_0003);
    rd("R4", 2'd1, 32'hAAAA_0000);

    // R5 write wins over tick
    wr("R5", 2'd0, 32'h0000_0100, 1'b1);
    rd("R5", 2'd0, 32'h0000_0100);
    rd("R5", 2'd1, 32'hAAAA_0000);

    // R11 unused slot
    wr("R11", 2'd3, 32'hDEAD_BEEF, 1'b0);
    rd("R11", 2'd3, 32'h0);
    rd("R11", 2'd0, 32'h0000_0100);

    // R8 positive over negative: no event; R6 countdown
    wr("R8", 2'd2, 32'd5, 1'b0);
    check("R8 no irq", {31'd0, irq_o}, 32'h0);
    idle("R6", 3, 1'b1);
    rd("R6", 2'd2, 32'd2);

    // R7 expiry 0 -> all ones
    idle("R7", 2, 1'b1);
    check("R7 at zero", {31'd0, irq_o}, 32'h0);
    idle("R7", 1, 1'b1);
    check("R7 expiry irq", {31'd0, irq_o}, 32'h1);
    rd("R7", 2'd2, 32'hFFFF_FFFF);

    // R10 hold then acknowledge
    idle("R10", 3, 1'b0);
    check("R10 held", {31'd0, irq_o}, 32'h1);
    step("R10", 1'b0, 1'b0, 1'b0, 2'd0, 32'h0, 1'b1);
    check("R10 cleared", {31'd0, irq_o}, 32'h0);

    // R8 negative over negative, then negative over positive
    wr("R8", 2'd2, 32'h8000_0000, 1'b0);
    check("R8 neg over neg", {31'd0, irq_o}, 32'h0);
    wr("R8", 2'd2, 32'h0000_0010, 1'b0);
    wr("R8", 2'd2, 32'h9000_0000, 1'b0);
    check("R8 neg over pos", {31'd0, irq_o}, 32'h1);
    step("R10", 1'b0, 1'b0, 1'b0, 2'd0, 32'h0, 1'b1);

    // R7 crossing 0x80000000 -> 0x7FFFFFFF raises nothing
    wr("R7", 2'd2, 32'h8000_0000, 1'b0);
    idle("R7", 1, 1'b1);
    check("R7 no irq", {31'd0, irq_o}, 32'h0);
    rd("R7", 2'd2, 32'h7FFF_FFFF);

    // R9 write wins over tick
    wr("R9", 2'd2, 32'h0000_0020, 1'b1);
    rd("R9", 2'd2, 32'h0000_0020);

    // R10 event and ack together, irq low before
    wr("R10", 2'd2, 32'h0, 1'b0);
    step("R10", 1'b1, 1'b0, 1'b0, 2'd0, 32'h0, 1'b1);
    check("R10 event beats ack", {31'd0, irq_o}, 32'h1);
    // R10 event and ack together, irq high before
    wr("R10", 2'd2, 32'h0, 1'b0);
    step("R10", 1'b1, 1'b0, 1'b0, 2'd0, 32'h0, 1'b1);
    check("R10 event beats ack held", {31'd0, irq_o}, 32'h1);

    // mixed traffic against the model
    for (int i = 0; i < 400; i++) begin
      logic [31:0] d;
      d = $urandom;
      if ($urandom_range(0, 3) == 0) d = $urandom_range(0, 3);
      step("model", 1'($urandom_range(0, 1)), ($urandom_range(0, 5) == 0),
           ($urandom_range(0, 2) == 0), 2'($urandom_range(0, 3)), d,
           ($urandom_range(0, 7) == 0));
    end

    finish_run();
  end
endmodule